// File: doc/BRIEF.md
# In-Order Multi-Wide Issue Stage

This block is the issue stage of a wide in-order pipeline. It holds a small window of decoded instructions, one slot per issue lane. Every cycle it grants issue to the longest run of window entries, counted from the oldest, that are free of hazards. An entry is checked against every older entry in the window and against a scoreboard of registers that still have a write outstanding. The first entry that cannot go stops every younger entry for that cycle, so issue is always in program order.

The window refills from the instruction buffer in one of two ways, chosen by an input. In fixed mode a new group is loaded only once the whole current group has issued. In gliding mode the survivors move down to the oldest slots and the freed slots are filled again in the same cycle.

There is no register renaming, so write-after-read and write-after-write conflicts block issue just as read-after-write conflicts do. The pending bits in the scoreboard are set when a writing instruction issues. They are cleared through a writeback clear vector, and a clear is seen by the hazard check in the same cycle it arrives.

Top module: `inorder_issue_stage`

## Requirements
- R1: While reset is asserted, the window empties and every scoreboard bit clears. In the first cycle after reset, no lane is granted and nothing is taken from the instruction buffer.
- R2: `issue_vld` is always a contiguous run of ones that starts at lane 0. Lane i carries the i-th oldest window entry. Each lane occupies bits [i*OP_W +: OP_W], where OP_W = 3*REG_W+1. Inside a lane, bits [REG_W-1:0] are source A, [2*REG_W-1:REG_W] are source B, [3*REG_W-1:2*REG_W] are the destination, and bit 3*REG_W is the write enable.
- R3: An entry that reads a register written by an older entry in the window is not issued in that cycle, and neither is any younger entry.
- R4: An entry that writes a register that an older window entry reads, or that an older window entry also writes, is not issued in that cycle.
- R5: An entry whose source register is pending in the scoreboard is blocked, unless `wb_clear` has that register's bit set in the same cycle.
- R6: Issuing an entry with its write enable set marks its destination pending from the next cycle until the register is cleared. A later writer of a pending register is blocked. If a clear and a new issue hit the same register in the same cycle, the register stays pending.
- R7: With `refill_glide` low, `fetch_take` is nonzero only in a cycle in which every occupied window entry issues. In that cycle it takes as many offered entries as fit, up to the issue width.
- R8: With `refill_glide` high, the window takes min(free slots after this cycle's issue, offered count) entries every cycle. The offered count is the number of leading set bits of `fetch_vld`.
- R9: The buffer entries taken are always the oldest of those offered. Lane i of `fetch_op` is older than lane i+1, and taken entries join the window behind every entry still waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refill_glide | input | 1 | 0 selects fixed-group refill, 1 selects gliding refill |
| fetch_vld | input | ISSUE_W | Valid bits of the offered buffer entries, lane 0 oldest |
| fetch_op | input | ISSUE_W*OP_W | Offered decoded entries, packed as in R2 |
| fetch_take | output | CNT_W | Number of offered entries accepted this cycle |
| wb_clear | input | NREGS | One bit per register; a set bit clears that register's pending bit |
| issue_vld | output | ISSUE_W | Per-lane issue grant, a prefix from lane 0 |
| issue_op | output | ISSUE_W*OP_W | Entries in the window, oldest in lane 0; a lane is meaningful only where granted |

## Verification
The bench builds the block three lanes wide with eight architectural registers. With so few registers, random streams keep running into intra-window and scoreboard conflicts. With three lanes, partial groups, a dependency in the middle of a group, and the different refill timing of the two modes all show up within a few instructions. The bench runs the same instruction lists in both refill modes. It varies how many entries it offers each cycle and whether pending registers are released at once, never, or at random. Each cycle it compares the grant, the issued entries and the take count against its own model of the window.

// File: rtl/ios_pkg.sv
package ios_pkg;

  // Refill policy for the issue window
  typedef enum logic {
    REFILL_FIXED = 1'b0,
    REFILL_GLIDE = 1'b1
  } refill_e;

endpackage

// File: rtl/ios_scoreboard.sv
module ios_scoreboard #(
  parameter int ISSUE_W = 4,
  parameter int NREGS   = 16,
  parameter int REG_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NREGS-1:0]           wb_clear,
  input  logic [ISSUE_W-1:0]         set_vld,
  input  logic [ISSUE_W*REG_W-1:0]   set_idx,
  output logic [NREGS-1:0]           pend_eff
);

  logic [NREGS-1:0] pend_q;
  logic [NREGS-1:0] pend_d;
  logic             pend_en;

  // writeback clears are visible to the hazard check in the same cycle
  assign pend_eff = pend_q & ~wb_clear;

  always_comb begin
    pend_d = pend_eff;
    for (int i = 0; i < ISSUE_W; i++) begin
      if (set_vld[i]) begin
        pend_d[set_idx[i*REG_W +: REG_W]] = 1'b1;
      end
    end
    pend_en = (|wb_clear) | (|set_vld);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/ios_hazard.sv
module ios_hazard #(
  parameter int ISSUE_W = 4,
  parameter int NREGS   = 16,
  parameter int REG_W   = 4,
  parameter int OP_W    = 3*REG_W+1,
  parameter int CNT_W   = 3
) (
  input  logic [ISSUE_W*OP_W-1:0] win_op,
  input  logic [ISSUE_W-1:0]      win_vld,
  input  logic [NREGS-1:0]        pend_eff,
  output logic [ISSUE_W-1:0]      grant,
  output logic [CNT_W-1:0]        grant_cnt
);

  logic [REG_W-1:0] src_a [ISSUE_W];
  logic [REG_W-1:0] src_b [ISSUE_W];
  logic [REG_W-1:0] dst   [ISSUE_W];
  logic             wr    [ISSUE_W];
  logic [ISSUE_W-1:0] stall;

  for (genvar g = 0; g < ISSUE_W; g++) begin : g_field
    assign src_a[g] = win_op[g*OP_W +: REG_W];
    assign src_b[g] = win_op[g*OP_W + REG_W +: REG_W];
    assign dst[g]   = win_op[g*OP_W + 2*REG_W +: REG_W];
    assign wr[g]    = win_op[g*OP_W + 3*REG_W];
  end

  // per-entry stall: empty slot, scoreboard conflict, or conflict with an older entry
  always_comb begin
    for (int j = 0; j < ISSUE_W; j++) begin
      stall[j] = ~win_vld[j]
               | pend_eff[src_a[j]]
               | pend_eff[src_b[j]]
               | (wr[j] & pend_eff[dst[j]]);
      for (int i = 0; i < j; i++) begin
        // true dependency on an older writer
        if (wr[i] && (dst[i] == src_a[j] || dst[i] == src_b[j])) stall[j] = 1'b1;
        // overwrite of a register an older entry still reads
        if (wr[j] && (dst[j] == src_a[i] || dst[j] == src_b[i])) stall[j] = 1'b1;
        // two writers of one register
        if (wr[i] && wr[j] && dst[i] == dst[j]) stall[j] = 1'b1;
      end
    end
  end

  // in-order: the first stalled entry stops all younger ones
  always_comb begin
    logic run;
    run       = 1'b1;
    grant_cnt = '0;
    for (int j = 0; j < ISSUE_W; j++) begin
      run      = run & ~stall[j];
      grant[j] = run;
      if (run) grant_cnt = grant_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/ios_window.sv
module ios_window
  import ios_pkg::*;
#(
  parameter int ISSUE_W = 4,
  parameter int OP_W    = 13,
  parameter int CNT_W   = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    glide,
  input  logic [ISSUE_W-1:0]      fetch_vld,
  input  logic [ISSUE_W*OP_W-1:0] fetch_op,
  input  logic [CNT_W-1:0]        issue_cnt,
  output logic [CNT_W-1:0]        fetch_take,
  output logic [ISSUE_W*OP_W-1:0] win_op,
  output logic [ISSUE_W-1:0]      win_vld,
  output logic [CNT_W-1:0]        occ
);

  logic [OP_W-1:0]  slot_q [ISSUE_W];
  logic [OP_W-1:0]  slot_d [ISSUE_W];
  logic [CNT_W-1:0] occ_q;
  logic [CNT_W-1:0] occ_d;
  logic [CNT_W-1:0] take_c;
  logic             upd;

  always_comb begin
    int  offer;
    int  rem;
    int  room;
    int  tk;
    int  idx;
    int  f;
    logic run;
    offer = 0;
    run   = 1'b1;
    for (int i = 0; i < ISSUE_W; i++) begin
      run = run & fetch_vld[i];
      if (run) offer++;
    end
    rem  = int'(occ_q) - int'(issue_cnt);
    room = ISSUE_W - rem;
    if (refill_e'(glide) == REFILL_GLIDE) begin
      tk = (offer < room) ? offer : room;
    end else begin
      tk = (rem == 0) ? offer : 0;
    end
    // survivors slide to the oldest slots, new entries go behind them
    for (int t = 0; t < ISSUE_W; t++) begin
      slot_d[t] = slot_q[t];
      idx = t + int'(issue_cnt);
      f   = t - rem;
      if (t < rem && idx < ISSUE_W) begin
        slot_d[t] = slot_q[idx];
      end else if (f >= 0 && f < tk) begin
        slot_d[t] = fetch_op[f*OP_W +: OP_W];
      end
    end
    take_c = CNT_W'(tk);
    occ_d  = CNT_W'(rem + tk);
    upd    = (issue_cnt != '0) || (tk != 0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
    end else if (upd) begin
      occ_q <= occ_d;
    end
  end

  always_ff @(posedge clk) begin
    if (upd) begin
      for (int t = 0; t < ISSUE_W; t++) begin
        slot_q[t] <= slot_d[t];
      end
    end
  end

  for (genvar g = 0; g < ISSUE_W; g++) begin : g_out
    assign win_op[g*OP_W +: OP_W] = slot_q[g];
    assign win_vld[g]             = (int'(occ_q) > g);
  end

  assign fetch_take = take_c;
  assign occ        = occ_q;

endmodule

// File: rtl/inorder_issue_stage.sv
module inorder_issue_stage #(
  parameter int ISSUE_W = 4,
  parameter int NREGS   = 16,
  localparam int REG_W  = $clog2(NREGS),
  localparam int OP_W   = 3*REG_W+1,
  localparam int CNT_W  = $clog2(ISSUE_W+1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    refill_glide,
  input  logic [ISSUE_W-1:0]      fetch_vld,
  input  logic [ISSUE_W*OP_W-1:0] fetch_op,
  output logic [CNT_W-1:0]        fetch_take,
  input  logic [NREGS-1:0]        wb_clear,
  output logic [ISSUE_W-1:0]      issue_vld,
  output logic [ISSUE_W*OP_W-1:0] issue_op
);

  logic [ISSUE_W*OP_W-1:0]  win_op;
  logic [ISSUE_W-1:0]       win_vld;
  logic [CNT_W-1:0]         occ;
  logic [ISSUE_W-1:0]       grant;
  logic [CNT_W-1:0]         grant_cnt;
  logic [NREGS-1:0]         pend_eff;
  logic [ISSUE_W-1:0]       set_vld;
  logic [ISSUE_W*REG_W-1:0] set_idx;

  ios_window #(
    .ISSUE_W (ISSUE_W),
    .OP_W    (OP_W),
    .CNT_W   (CNT_W)
  ) win_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .glide      (refill_glide),
    .fetch_vld  (fetch_vld),
    .fetch_op   (fetch_op),
    .issue_cnt  (grant_cnt),
    .fetch_take (fetch_take),
    .win_op     (win_op),
    .win_vld    (win_vld),
    .occ        (occ)
  );

  ios_hazard #(
    .ISSUE_W (ISSUE_W),
    .NREGS   (NREGS),
    .REG_W   (REG_W),
    .OP_W    (OP_W),
    .CNT_W   (CNT_W)
  ) haz_i (
    .win_op    (win_op),
    .win_vld   (win_vld),
    .pend_eff  (pend_eff),
    .grant     (grant),
    .grant_cnt (grant_cnt)
  );

  for (genvar g = 0; g < ISSUE_W; g++) begin : g_set
    assign set_vld[g]                 = grant[g] & win_op[g*OP_W + 3*REG_W];
    assign set_idx[g*REG_W +: REG_W]  = win_op[g*OP_W + 2*REG_W +: REG_W];
  end

  ios_scoreboard #(
    .ISSUE_W (ISSUE_W),
    .NREGS   (NREGS),
    .REG_W   (REG_W)
  ) sb_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wb_clear (wb_clear),
    .set_vld  (set_vld),
    .set_idx  (set_idx),
    .pend_eff (pend_eff)
  );

  assign issue_vld = grant;
  assign issue_op  = win_op;

endmodule

// File: rtl/ios_checker.sv
module ios_checker #(
  parameter int ISSUE_W = 4,
  parameter int NREGS   = 16,
  parameter int REG_W   = 4,
  parameter int CNT_W   = 3,
  localparam int OP_W   = 3*REG_W+1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 glide,
  input logic [ISSUE_W-1:0]   fetch_vld,
  input logic [CNT_W-1:0]     fetch_take,
  input logic [ISSUE_W-1:0]   issue_vld,
  input logic [2*OP_W-1:0]    win_pair,
  input logic [1:0]           win_vld,
  input logic [NREGS-1:0]     pend_eff,
  input logic [NREGS-1:0]     wb_clear,
  input logic [CNT_W-1:0]     occ
);

  logic [REG_W-1:0] sa0, sb0, d0, sa1, sb1, d1;
  logic             w0, w1;

  assign sa0 = win_pair[0 +: REG_W];
  assign sb0 = win_pair[REG_W +: REG_W];
  assign d0  = win_pair[2*REG_W +: REG_W];
  assign w0  = win_pair[3*REG_W];
  assign sa1 = win_pair[OP_W +: REG_W];
  assign sb1 = win_pair[OP_W + REG_W +: REG_W];
  assign d1  = win_pair[OP_W + 2*REG_W +: REG_W];
  assign w1  = win_pair[OP_W + 3*REG_W];

  // R2
  grant_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((issue_vld & (issue_vld + ISSUE_W'(1))) == '0));

  // R3
  raw_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vld[0] && win_vld[1] && w0 && (d0 == sa1 || d0 == sb1)) |-> !issue_vld[1]);

  // R4
  waw_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vld[0] && win_vld[1] && w0 && w1 && d0 == d1) |-> !issue_vld[1]);

  // R5
  pend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vld[0] && (pend_eff[sa0] || pend_eff[sb0])) |-> !issue_vld[0]);

  // R6
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld[0] && w0) |=> (pend_eff[$past(d0)] || wb_clear[$past(d0)]));

  // R7
  fixed_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!glide && fetch_take != '0) |-> ($countones(issue_vld) == int'(occ)));

  // R8
  glide_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (glide && (&fetch_vld)) |->
      (int'(fetch_take) == ISSUE_W - int'(occ) + $countones(issue_vld)));

endmodule

bind inorder_issue_stage ios_checker #(
  .ISSUE_W (ISSUE_W),
  .NREGS   (NREGS),
  .REG_W   (REG_W),
  .CNT_W   (CNT_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .glide      (refill_glide),
  .fetch_vld  (fetch_vld),
  .fetch_take (fetch_take),
  .issue_vld  (issue_vld),
  .win_pair   (win_op[2*OP_W-1:0]),
  .win_vld    (win_vld[1:0]),
  .pend_eff   (pend_eff),
  .wb_clear   (wb_clear),
  .occ        (occ)
);

// File: tb/inorder_issue_stage_tb_top.sv
`timescale 1ns/1ps
module inorder_issue_stage_tb_top;

  localparam int W   = 3;
  localparam int NR  = 8;
  localparam int RW  = 3;
  localparam int OPW = 3*RW+1;
  localparam int CW  = 2;

  logic            clk;
  logic            rst_n;
  logic            refill_glide;
  logic [W-1:0]    fetch_vld;
  logic [W*OPW-1:0] fetch_op;
  logic [CW-1:0]   fetch_take;
  logic [NR-1:0]   wb_clear;
  logic [W-1:0]    issue_vld;
  logic [W*OPW-1:0] issue_op;

  inorder_issue_stage #(.ISSUE_W(W), .NREGS(NR)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .refill_glide (refill_glide),
    .fetch_vld    (fetch_vld),
    .fetch_op     (fetch_op),
    .fetch_take   (fetch_take),
    .wb_clear     (wb_clear),
    .issue_vld    (issue_vld),
    .issue_op     (issue_op)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;

  // program under test and reference model state
  logic [OPW-1:0] prog [64];
  int             plen;
  int             ptr;
  logic [OPW-1:0] mwin [W];
  int             mcnt;
  logic [NR-1:0]  mpend;
  logic [31:0]    rs;

  typedef struct {
    logic [W-1:0]     vld;
    logic [W*OPW-1:0] ops;
    int               take;
    string            tag;
  } exp_t;
  exp_t exp_q[$];

  function automatic logic [OPW-1:0] mk(int d, int a, int b, bit w);
    return {w, RW'(d), RW'(b), RW'(a)};
  endfunction

  function automatic logic [31:0] rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs;
  endfunction

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #800000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    summary();
  end

  // monitor: pop the expected group and compare with the design
  task automatic monitor(bit glide_m);
    exp_t e;
    logic [W*OPW-1:0] mask;
    e = exp_q.pop_front();
    mask = '0;
    for (int i = 0; i < W; i++) if (issue_vld[i]) mask[i*OPW +: OPW] = '1;
    n_tests++;
    if (issue_vld !== e.vld || (issue_op & mask) !== e.ops) begin
      n_fail++;
      $display("FAIL %s issue: actual vld=%b ops=%h, expected vld=%b ops=%h",
               e.tag, issue_vld, issue_op & mask, e.vld, e.ops);
    end
    n_tests++;
    if (int'(fetch_take) != e.take) begin
      n_fail++;
      $display("FAIL %s take: actual %0d, expected %0d",
               glide_m ? "R8/R9" : "R7/R9", fetch_take, e.take);
    end
  endtask

  // one cycle: drive, model, compare, advance model
  task automatic step(string tag, bit glide_m, int wbm, bit rnd_offer);
    int n, lim, k, rem, room, tk;
    logic [NR-1:0] eff;
    logic [OPW-1:0] nw [W];
    exp_t e;
    @(negedge clk);
    refill_glide = glide_m;
    lim = rnd_offer ? int'(rnd() % (W+1)) : W;
    n = plen - ptr;
    if (n > W) n = W;
    if (n > lim) n = lim;
    fetch_vld = '0;
    fetch_op  = '0;
    for (int i = 0; i < n; i++) begin
      fetch_vld[i] = 1'b1;
      fetch_op[i*OPW +: OPW] = prog[ptr+i];
    end
    if (wbm == 0)      wb_clear = mpend;
    else if (wbm == 1) wb_clear = '0;
    else               wb_clear = mpend & NR'(rnd());
    #1;
    eff = mpend & ~wb_clear;
    k = 0;
    for (int j = 0; j < mcnt; j++) begin
      logic [RW-1:0] a, b, d;
      bit w, ok;
      a = mwin[j][RW-1:0]; b = mwin[j][2*RW-1:RW];
      d = mwin[j][3*RW-1:2*RW]; w = mwin[j][3*RW];
      ok = !(eff[a] || eff[b] || (w && eff[d]));
      for (int i = 0; i < j; i++) begin
        logic [RW-1:0] ai, bi, di;
        bit wi;
        ai = mwin[i][RW-1:0]; bi = mwin[i][2*RW-1:RW];
        di = mwin[i][3*RW-1:2*RW]; wi = mwin[i][3*RW];
        if (wi && (di == a || di == b)) ok = 0;
        if (w && (d == ai || d == bi)) ok = 0;
        if (wi && w && di == d) ok = 0;
      end
      if (k == j && ok) k++;
    end
    rem  = mcnt - k;
    room = W - rem;
    if (glide_m) tk = (n < room) ? n : room;
    else         tk = (rem == 0) ? n : 0;
    e.vld = '0;
    e.ops = '0;
    for (int i = 0; i < k; i++) begin
      e.vld[i] = 1'b1;
      e.ops[i*OPW +: OPW] = mwin[i];
    end
    e.take = tk;
    e.tag  = tag;
    exp_q.push_back(e);
    monitor(glide_m);
    for (int i = 0; i < k; i++) if (mwin[i][3*RW]) eff[mwin[i][3*RW-1:2*RW]] = 1'b1;
    mpend = eff;
    for (int t = 0; t < W; t++) nw[t] = '0;
    for (int t = 0; t < rem; t++) nw[t] = mwin[t+k];
    for (int t = 0; t < tk; t++) nw[rem+t] = prog[ptr+t];
    for (int t = 0; t < W; t++) mwin[t] = nw[t];
    mcnt = rem + tk;
    ptr  = ptr + tk;
  endtask

  task automatic run(string tag, bit glide_m, int wbm, bit rnd_offer, int maxc, bit drain);
    for (int c = 0; c < maxc; c++) begin
      if (drain && ptr >= plen && mcnt == 0) break;
      step(tag, glide_m, wbm, rnd_offer);
    end
  endtask

  task automatic start();
    ptr = 0;
  endtask

  task automatic load_raw();
    plen = 6;
    prog[0] = mk(1, 2, 3, 1);
    prog[1] = mk(4, 1, 5, 1);
    prog[2] = mk(6, 7, 0, 1);
    prog[3] = mk(2, 6, 3, 1);
    prog[4] = mk(5, 4, 4, 1);
    prog[5] = mk(7, 0, 0, 1);
  endtask

  task automatic load_false();
    plen = 5;
    prog[0] = mk(1, 2, 3, 1);
    prog[1] = mk(2, 4, 5, 1);  // overwrites a source of the older entry
    prog[2] = mk(6, 7, 7, 1);
    prog[3] = mk(6, 1, 1, 1);  // second writer of r6
    prog[4] = mk(3, 4, 5, 0);
  endtask

  initial begin
    rs = 32'h1234_abcd;
    rst_n = 1'b0;
    refill_glide = 1'b0;
    fetch_vld = '0;
    fetch_op = '0;
    wb_clear = '0;
    mcnt = 0;
    mpend = '0;
    plen = 0;
    ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty window after reset, nothing offered
    @(negedge clk);
    #1;
    n_tests++;
    if (issue_vld !== '0 || fetch_take !== '0) begin
      n_fail++;
      $display("FAIL R1 reset: actual vld=%b take=%0d, expected vld=0 take=0",
               issue_vld, fetch_take);
    end

    // R3: read-after-write inside the window, both refill modes
    load_raw();  start(); run("R3", 1'b0, 0, 1'b0, 50, 1'b1);
    load_raw();  start(); run("R3", 1'b1, 0, 1'b0, 50, 1'b1);

    // R4: write-after-read and write-after-write
    load_false(); start(); run("R4", 1'b0, 0, 1'b0, 50, 1'b1);
    load_false(); start(); run("R4", 1'b1, 0, 1'b0, 50, 1'b1);

    // R5: source held pending by the scoreboard until cleared
    plen = 2;
    prog[0] = mk(1, 2, 3, 1);
    prog[1] = mk(4, 1, 5, 1);
    start(); run("R5", 1'b1, 1, 1'b0, 4, 1'b0);
    run("R5", 1'b1, 0, 1'b0, 20, 1'b1);

    // R6: destination held pending blocks a later writer
    plen = 2;
    prog[0] = mk(1, 2, 3, 1);
    prog[1] = mk(1, 5, 6, 1);
    start(); run("R6", 1'b0, 1, 1'b0, 4, 1'b0);
    run("R6", 1'b0, 0, 1'b0, 20, 1'b1);

    // R2: independent stream with partial offers
    plen = 8;
    for (int i = 0; i < 8; i++) prog[i] = mk(i, (i + 3) % 8, (i + 5) % 8, 1'b0);
    start(); run("R2/R7", 1'b0, 0, 1'b1, 80, 1'b1);
    start(); run("R2/R8", 1'b1, 0, 1'b1, 80, 1'b1);

    // R9: random streams, random offers and random release
    for (int m = 0; m < 2; m++) begin
      plen = 60;
      for (int i = 0; i < 60; i++) begin
        logic [31:0] r;
        r = rnd();
        prog[i] = mk(int'(r[2:0]), int'(r[5:3]), int'(r[8:6]), r[9] | r[10]);
      end
      start(); run("R9/R2", m[0], 2, 1'b1, 3000, 1'b1);
      run("R9/R2", m[0], 0, 1'b0, 20, 1'b1);
    end

    summary();
  end

endmodule